// File: doc/BRIEF.md
# Key-Guarded Switch Configuration Register

This block holds one 32-bit configuration word whose nine low bits drive enable lines for a group of analog switches: a supply selector, four isolation switches and four short-to-ground switches. Software changes the word through a plain register-bus write. Each write must carry a fixed 8-bit key in the top byte of the same word. A write with a wrong key is discarded, so stray or corrupted writes cannot change the switches.

The block also keeps an unlocked status bit. A write with the correct key sets it. A write with the wrong key clears it and leaves the fields alone, so software can relock the register on purpose by writing any word with a bad key. Reads are registered and return the nine fields in place. The key byte and the reserved bits always read as zero. The bench outputs for the switches come straight from the stored bits.

Top module: `keyed_cfg_reg`

## Requirements
- R1: After reset the stored fields are 0x00F (supply_sel 0, iso_en 0x0, gnd_short_en 0xF), unlocked is 0 and rd_valid is 0.
- R2: A write (wr_en 1) whose bits 31:24 equal 0x5A stores wr_data[8:0] and sets unlocked. Both are visible from the clock edge that takes the write.
- R3: A write whose bits 31:24 differ from 0x5A leaves all nine stored fields unchanged.
- R4: A write whose bits 31:24 differ from 0x5A clears unlocked at the same edge.
- R5: Read data bits 31:24 are always 0x00, whatever key was written.
- R6: Read data bits 23:9 are always zero, even after a correct-key write with ones in those bits.
- R7: supply_sel is stored bit 8, iso_en[3:0] is stored bits 7:4 and gnd_short_en[3:0] is stored bits 3:0. The same bits appear at the same positions in rd_data.
- R8: wr_strb has no effect: a correct-key write updates all nine fields even when wr_strb is 4'b0000 or a partial mask.
- R9: rd_en sampled high at an edge makes rd_valid 1 and rd_data valid for the following cycle. rd_valid is 0 after an edge with rd_en low.
- R10: When a read and a write are taken at the same edge, the read returns the fields held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request, one word per cycle |
| wr_data | input | 32 | Write word: key in 31:24, fields in 8:0 |
| wr_strb | input | 4 | Byte-lane strobes, ignored |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Registered read word |
| rd_valid | output | 1 | rd_data holds a read result |
| supply_sel | output | 1 | Supply selector for the switches |
| iso_en | output | 4 | Isolation switch enables |
| gnd_short_en | output | 4 | Short-to-ground switch enables |
| unlocked | output | 1 | Last write carried the correct key |

## Verification
A read and a write can be taken at the same clock edge, and the write can carry either a good or a bad key. The bench issues both requests in one cycle with both kinds of key. The scoreboard predicts the read from its model state before it applies the write, so a read that returns the value just written is counted as a failure. Back-to-back writes that switch between good and bad keys exercise the unlocked bit and the field hold together.

// File: rtl/cfgkey_pkg.sv
// Package: shared widths and the layout of the switch-enable fields.
// Assumes the field word is nine bits: one supply select, four isolation
// enables and four ground-short enables, packed high to low.
package cfgkey_pkg;

    localparam int WORD_W  = 32;
    localparam int KEY_W   = 8;
    localparam int ISO_N   = 4;
    localparam int SHORT_N = 4;
    localparam int FIELD_W = 1 + ISO_N + SHORT_N;

    typedef struct packed {
        logic               supply;
        logic [ISO_N-1:0]   iso;
        logic [SHORT_N-1:0] shorts;
    } sw_fields_t;

endpackage

// File: rtl/cfgkey_match.sv
// Key comparator: classifies each write as good-key or bad-key.
// Assumes the key sits in the top KEY_W bits of the write word.
module cfgkey_match #(
    parameter int              DATA_W  = 32,
    parameter int              KEY_W   = 8,
    parameter logic [KEY_W-1:0] KEY_VAL = 8'h5A
) (
    input  logic             wr_en,
    input  logic [KEY_W-1:0] key_in,
    output logic             key_good,
    output logic             key_bad
);

    localparam int KEY_LSB = DATA_W - KEY_W;

    logic hit;
    logic unused_lsb;

    // Compare the incoming key with the fixed value.
    always_comb begin
        hit = (key_in == KEY_VAL);
    end

    // Split a write request into its two outcomes.
    always_comb begin
        key_good = wr_en & hit;
        key_bad  = wr_en & ~hit;
    end

    assign unused_lsb = (KEY_LSB < 0);

endmodule

// File: rtl/cfgkey_store.sv
// Field storage: one flop per field bit with its own reset value.
// Assumes load is already qualified by the key check.
module cfgkey_store #(
    parameter int                 FIELD_W   = 9,
    parameter logic [FIELD_W-1:0] RESET_VAL = 9'h00F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_data,
    output logic [FIELD_W-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < FIELD_W; gi++) begin : g_bit
            // Hold or load one field bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q[gi] <= RESET_VAL[gi];
                end else if (load) begin
                    q[gi] <= load_data[gi];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfgkey_lock.sv
// Unlock status: set by a good-key write, cleared by a bad-key write.
// Assumes good and bad are never high together.
module cfgkey_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic good,
    input  logic bad,
    output logic open_q
);

    // Track the result of the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (good) begin
            open_q <= 1'b1;
        end else if (bad) begin
            open_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cfgkey_readback.sv
// Read port: registers the fields into a full word with zeroed upper bits.
// Assumes the fields sit at the low end of the word.
module cfgkey_readback #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [FIELD_W-1:0] fields,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid
);

    localparam int PAD_W = DATA_W - FIELD_W;

    logic [DATA_W-1:0] word;

    // Zero-extend the field bits to a bus word.
    always_comb begin
        word = {{PAD_W{1'b0}}, fields};
    end

    // Capture the word and flag it for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= word;
            end
        end
    end

endmodule

// File: rtl/keyed_cfg_reg.sv
// Top: key-guarded switch configuration register.
// Every write carries its key in bits 31:24. Strobes are ignored and the
// word is taken whole. Outputs come straight from the stored fields.
module keyed_cfg_reg #(
    parameter logic [7:0] KEY_VAL    = 8'h5A,
    parameter logic [8:0] RESET_FLDS = 9'h00F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_strb,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        supply_sel,
    output logic [3:0]  iso_en,
    output logic [3:0]  gnd_short_en,
    output logic        unlocked
);
    import cfgkey_pkg::*;

    localparam int KEY_LSB = WORD_W - KEY_W;

    logic       key_good;
    logic       key_bad;
    logic [FIELD_W-1:0] fld_q;
    sw_fields_t fld_s;
    logic       unused_in;

    cfgkey_match #(
        .DATA_W (WORD_W),
        .KEY_W  (KEY_W),
        .KEY_VAL(KEY_VAL)
    ) u_match (
        .wr_en   (wr_en),
        .key_in  (wr_data[WORD_W-1:KEY_LSB]),
        .key_good(key_good),
        .key_bad (key_bad)
    );

    cfgkey_store #(
        .FIELD_W  (FIELD_W),
        .RESET_VAL(RESET_FLDS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (key_good),
        .load_data(wr_data[FIELD_W-1:0]),
        .q        (fld_q)
    );

    cfgkey_lock u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .good  (key_good),
        .bad   (key_bad),
        .open_q(unlocked)
    );

    cfgkey_readback #(
        .DATA_W (WORD_W),
        .FIELD_W(FIELD_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .fields  (fld_q),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    // Split the stored word into the named switch enables.
    always_comb begin
        fld_s        = sw_fields_t'(fld_q);
        supply_sel   = fld_s.supply;
        iso_en       = fld_s.iso;
        gnd_short_en = fld_s.shorts;
    end

    // Strobes and reserved write bits are taken and dropped on purpose.
    assign unused_in = ^{wr_strb, wr_data[KEY_LSB-1:FIELD_W]};

endmodule

// File: rtl/cfgkey_checker.sv
// Checker: temporal properties of the keyed register, bound to the top.
module cfgkey_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic        supply_sel,
    input logic [3:0]  iso_en,
    input logic [3:0]  gnd_short_en,
    input logic        unlocked
);

    logic [8:0] flds;
    assign flds = {supply_sel, iso_en, gnd_short_en};

    assert_good_key_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'h5A) |=> (flds == $past(wr_data[8:0]) && unlocked));

    assert_bad_key_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] != 8'h5A) |=> $stable(flds));

    assert_bad_key_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] != 8'h5A) |=> !unlocked);

    assert_key_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[31:24] == 8'h00);

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[23:9] == 15'h0);

    assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_read_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_read_old_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_data[8:0] == $past(flds));

endmodule

bind keyed_cfg_reg cfgkey_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .supply_sel  (supply_sel),
    .iso_en      (iso_en),
    .gnd_short_en(gnd_short_en),
    .unlocked    (unlocked)
);

// File: tb/sim_keyed_cfg_reg.sv
// Scoreboard bench: the driver pushes expected read words, the monitor pops them.
module sim_keyed_cfg_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        supply_sel;
    logic [3:0]  iso_en;
    logic [3:0]  gnd_short_en;
    logic        unlocked;

    int checks = 0;
    int errors = 0;
    logic [8:0] m_flds = 9'h00F;
    logic       m_unlk = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #10 clk = ~clk;

    keyed_cfg_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_strb(wr_strb), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .supply_sel(supply_sel), .iso_en(iso_en),
        .gnd_short_en(gnd_short_en), .unlocked(unlocked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one cycle of requests; the model updates after the read item is queued.
    task automatic access(input bit we, input logic [31:0] d, input logic [3:0] s,
                          input bit re, input string tag);
        @(negedge clk);
        wr_en = we; wr_data = d; wr_strb = s; rd_en = re;
        if (re) begin
            exp_q.push_back({23'h0, m_flds});
            tag_q.push_back(tag);
        end
        if (we) begin
            if (d[31:24] == 8'h5A) begin
                m_flds = d[8:0];
                m_unlk = 1'b1;
            end else begin
                m_unlk = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_strb = '0;
    endtask

    // Compare the switch outputs and unlock bit with the model.
    task automatic check_outs(input string req);
        check({req, " fields"}, {23'h0, supply_sel, iso_en, gnd_short_en}, {23'h0, m_flds});
        check({req, " unlocked"}, {31'h0, unlocked}, {31'h0, m_unlk});
    endtask

    // Monitor: pop and compare every read result.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected rd_valid", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_outs("R1");
        check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        access(1'b0, '0, '0, 1'b1, "R1 readback");

        // R2/R7 good key load, with reserved ones (R6)
        access(1'b1, 32'h5A00_FF35, 4'hF, 1'b0, "");
        check_outs("R2 R7");
        check("R7 supply_sel", {31'h0, supply_sel}, 32'h1);
        check("R7 iso_en", {28'h0, iso_en}, 32'h3);
        check("R7 gnd_short_en", {28'h0, gnd_short_en}, 32'h5);
        access(1'b0, '0, '0, 1'b1, "R6 R5 R7 readback");

        // R3/R4 bad key leaves fields, relocks
        access(1'b1, 32'hA500_00C0, 4'hF, 1'b0, "");
        check_outs("R3 R4");
        access(1'b1, 32'h5B00_0000, 4'hF, 1'b0, "");
        check_outs("R3 near key");
        access(1'b0, '0, '0, 1'b1, "R3 readback");

        // R8 strobes ignored
        access(1'b1, 32'h5A00_00AA, 4'h0, 1'b0, "");
        check_outs("R8 zero strobe");
        access(1'b1, 32'h5A00_0155, 4'h2, 1'b0, "");
        check_outs("R8 partial strobe");

        // R10 read and write in the same cycle, good then bad key
        access(1'b1, 32'h5A00_0012, 4'hF, 1'b1, "R10 good key same cycle");
        check_outs("R10 good");
        access(1'b1, 32'h0000_01FF, 4'hF, 1'b1, "R10 bad key same cycle");
        check_outs("R10 bad");

        // R9 back-to-back reads
        access(1'b0, '0, '0, 1'b1, "R9 read a");
        access(1'b0, '0, '0, 1'b1, "R9 read b");
        @(negedge clk);
        check("R9 idle rd_valid", {31'h0, rd_valid}, 32'h0);

        // R5 full-ones key-bad then good write with all ones
        access(1'b1, 32'hFFFF_FFFF, 4'hF, 1'b0, "");
        check_outs("R4 all ones");
        access(1'b1, 32'h5AFF_FFFF, 4'hF, 1'b1, "R5 pre-write read");
        access(1'b0, '0, '0, 1'b1, "R5 R6 all ones readback");
        check_outs("R2 all ones");

        repeat (3) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule